// File: doc/BRIEF.md
# UART Receive FIFO Interrupt Generator

This block produces the receive-side interrupt sources of a UART whose received characters collect in a FIFO. It watches the FIFO occupancy against a programmed trigger level and raises a level-tracking data request. It keeps a data-ready flag for the host. It also runs an idle timer, and that timer raises a character timeout when characters wait in the FIFO but no traffic in either direction has happened for four character times. A line-error indication is also folded in. All active sources are reduced to one prioritised identification code.

The FIFO storage, the bit-level receiver and the baud generator sit outside this block. The surrounding UART supplies the occupancy count, a push strobe for each character moved in from the shift register and a pop strobe for each host read. It also supplies the length of one character in system clock cycles, plus the length of one bit for frames with two stop bits. Two enables gate the interrupt side: one for the receive FIFO and one for receive interrupts.

Top module: `uart_rx_irq_gen`

## Requirements
- R1: `trig_req` is high while `fifo_count > trig_level` and low while `fifo_count < trig_level`, in the same cycle as the count. When the two are equal it keeps the value it had in the previous cycle.
- R2: With no line error active, `irq_id` is 2 (trigger) whenever `trig_req` is high, even if a timeout is also pending.
- R3: A line error with both enables high gives `irq_id` = 3 no matter what other source is active. With nothing active `irq_id` is 0.
- R4: `data_ready` is set on the clock edge after a `push`. It is cleared on an edge where `fifo_count` is 0 and no push occurs, and otherwise it holds. It does not depend on the enables.
- R5: `tmo_req` rises, and `irq_id` shows 1 (timeout), on the (4*`char_clks` - P + 1)th rising edge after the edge that took a `push`. P is 0 here, or the R8 value. This holds only while `fifo_count` is nonzero and no push or pop arrives in between. With an empty FIFO it never rises.
- R6: A `pop` clears a pending timeout on the edge that takes it and restarts the timer from zero. The next timeout then rises 4*`char_clks` + 1 edges after the pop.
- R7: When no timeout is pending, a `push` restarts the timer. When a timeout is pending, a `push` leaves `tmo_req` high.
- R8: With `two_stop` high, a push preloads the timer with `bit_clks`, so the idle time counts from the first stop bit. P = `bit_clks`, limited to 4*`char_clks`.
- R9: While `fifo_en` or `rx_irq_en` is low, `trig_req` and `tmo_req` are 0, `irq_id` is 0 and the timer is held at zero. After re-enabling, a timeout takes the full 4*`char_clks` + 1 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | Receive FIFO enable |
| rx_irq_en | input | 1 | Receive interrupt enable |
| fifo_count | input | CNT_W | Current receive FIFO occupancy |
| trig_level | input | CNT_W | Programmed trigger level |
| push | input | 1 | One character moved from shift register into FIFO |
| pop | input | 1 | Host read one character from FIFO |
| line_err | input | 1 | Receive line error present |
| two_stop | input | 1 | Frame uses two stop bits |
| char_clks | input | CT_W | System clocks per character |
| bit_clks | input | CT_W | System clocks per bit |
| data_ready | output | 1 | At least one character received and not drained |
| trig_req | output | 1 | Trigger-level read request |
| tmo_req | output | 1 | Character timeout request |
| irq_id | output | 2 | 0 none, 1 timeout, 2 trigger, 3 line error |

## Verification
Some properties are checked on every cycle. These are the trigger comparison against count and level, and the priority of line error over trigger and of trigger over timeout. Also checked are the setting of data-ready after a push, the clearing of a timeout by a pop, that a pending timeout survives a push, and the silencing of all outputs while disabled. Other behaviour only shows in the bench's scenarios: the exact edge counts before a timeout, the preload for two stop bits, the timer restart on a second push, and the full-length wait after re-enabling. The trigger hold at equality also needs a scenario, because it depends on history.

// File: rtl/uart_rx_irq_pkg.sv
// Shared types for the receive interrupt generator.
package uart_rx_irq_pkg;
    // Interrupt identification codes; higher value means higher priority.
    typedef enum logic [1:0] {
        IRQ_NONE     = 2'd0,
        IRQ_TIMEOUT  = 2'd1,
        IRQ_TRIGGER  = 2'd2,
        IRQ_LINE_ERR = 2'd3
    } irq_id_e;
endpackage

// File: rtl/rxi_trig_level.sv
// Trigger-level request: high above the level, low below it, holds at equality.
// Assumes fifo_count and trig_level share a width and are stable around edges.
module rxi_trig_level #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic [CNT_W-1:0] trig_level,
    output logic             trig_req
);
    logic held_q;

    // Combinational request with equality resolved by last cycle's value.
    always_comb begin
        trig_req = en && ((fifo_count > trig_level) ||
                          ((fifo_count == trig_level) && held_q));
    end

    // Remember the previous output for the equality case.
    always_ff @(posedge clk) begin
        if (!rst_n) held_q <= 1'b0;
        else        held_q <= trig_req;
    end

    AST_TRIG_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && fifo_count > trig_level) |-> trig_req);          // R1
    AST_TRIG_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_count < trig_level) |-> !trig_req);               // R1
endmodule

// File: rtl/rxi_char_timeout.sv
// Four-character idle timer. It restarts on push (unless a timeout is pending)
// and on pop, and flags a timeout while the FIFO holds data.
// Assumes char_clks and bit_clks are already in system clock cycles.
module rxi_char_timeout #(
    parameter int CT_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            fifo_nonempty,
    input  logic            push,
    input  logic            pop,
    input  logic            two_stop,
    input  logic [CT_W-1:0] char_clks,
    input  logic [CT_W-1:0] bit_clks,
    output logic            tmo_req
);
    localparam int TW = CT_W + 2;

    logic [TW-1:0] limit;
    logic [TW-1:0] preload;
    logic [TW-1:0] tmr_q;
    logic          pend_q;

    // Threshold of four characters and the push preload, clipped to it.
    always_comb begin
        limit   = {char_clks, 2'b00};
        preload = two_stop ? {2'b00, bit_clks} : '0;
        if (preload > limit) preload = limit;
    end

    // Saturating idle counter and pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            tmr_q  <= '0;
            pend_q <= 1'b0;
        end else if (pop) begin
            tmr_q  <= '0;
            pend_q <= 1'b0;
        end else if (push && !pend_q) begin
            tmr_q  <= preload;
        end else if (!fifo_nonempty) begin
            tmr_q  <= '0;
            pend_q <= 1'b0;
        end else if (tmr_q < limit) begin
            tmr_q  <= tmr_q + 1'b1;
        end else begin
            pend_q <= 1'b1;
        end
    end

    // Output gated by the enables.
    always_comb tmo_req = pend_q && en;

    AST_TMO_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_req) |-> $past(fifo_nonempty));               // R5
    AST_POP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && pop) |=> !tmo_req);                              // R6
    AST_PUSH_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_req && push && !pop && fifo_nonempty && en) |=> (tmo_req || !en)); // R7
endmodule

// File: rtl/rxi_prio_enc.sv
// Reduces the active sources to one identification code: line error first,
// then trigger request, then timeout. Sources arrive already gated.
module rxi_prio_enc
    import uart_rx_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     line_irq,
    input  logic     trig_req,
    input  logic     tmo_req,
    output irq_id_e  irq_id
);
    // Fixed priority selection.
    always_comb begin
        if (line_irq)      irq_id = IRQ_LINE_ERR;
        else if (trig_req) irq_id = IRQ_TRIGGER;
        else if (tmo_req)  irq_id = IRQ_TIMEOUT;
        else               irq_id = IRQ_NONE;
    end

    AST_ERR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        line_irq |-> (irq_id == IRQ_LINE_ERR));                 // R3
    AST_TRIG_OVER_TMO: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_irq && trig_req) |-> (irq_id == IRQ_TRIGGER));   // R2
endmodule

// File: rtl/uart_rx_irq_gen.sv
// Receive-side interrupt generator for a FIFO-buffered UART. It combines the
// trigger request, the idle timeout, line errors and the data-ready flag.
// Assumes fifo_count is the occupancy seen by the host in the current cycle.
module uart_rx_irq_gen
    import uart_rx_irq_pkg::*;
#(
    parameter int CNT_W = 5,
    parameter int CT_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             rx_irq_en,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic [CNT_W-1:0] trig_level,
    input  logic             push,
    input  logic             pop,
    input  logic             line_err,
    input  logic             two_stop,
    input  logic [CT_W-1:0]  char_clks,
    input  logic [CT_W-1:0]  bit_clks,
    output logic             data_ready,
    output logic             trig_req,
    output logic             tmo_req,
    output logic [1:0]       irq_id
);
    logic    en;
    logic    line_irq;
    logic    nonempty;
    irq_id_e id_enc;

    // Shared enable and derived conditions.
    always_comb begin
        en       = fifo_en && rx_irq_en;
        line_irq = en && line_err;
        nonempty = (fifo_count != '0);
        irq_id   = id_enc;
    end

    // Data-ready: set by a push, cleared once the FIFO is empty.
    always_ff @(posedge clk) begin
        if (!rst_n)         data_ready <= 1'b0;
        else if (push)      data_ready <= 1'b1;
        else if (!nonempty) data_ready <= 1'b0;
    end

    rxi_trig_level #(.CNT_W(CNT_W)) i_trig (
        .clk(clk), .rst_n(rst_n), .en(en),
        .fifo_count(fifo_count), .trig_level(trig_level),
        .trig_req(trig_req)
    );

    rxi_char_timeout #(.CT_W(CT_W)) i_tmo (
        .clk(clk), .rst_n(rst_n), .en(en), .fifo_nonempty(nonempty),
        .push(push), .pop(pop), .two_stop(two_stop),
        .char_clks(char_clks), .bit_clks(bit_clks), .tmo_req(tmo_req)
    );

    rxi_prio_enc i_prio (
        .clk(clk), .rst_n(rst_n), .line_irq(line_irq),
        .trig_req(trig_req), .tmo_req(tmo_req), .irq_id(id_enc)
    );

    AST_DR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> data_ready);                                   // R4
    AST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (irq_id == 2'd0 && !trig_req && !tmo_req));     // R9
endmodule

// File: tb/test_uart_rx_irq_gen.sv
module test_uart_rx_irq_gen;
    localparam int CNT_W = 5;
    localparam int CT_W  = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             fifo_en = 1'b1, rx_irq_en = 1'b1;
    logic [CNT_W-1:0] fifo_count = '0, trig_level = '0;
    logic             push = 1'b0, pop = 1'b0, line_err = 1'b0, two_stop = 1'b0;
    logic [CT_W-1:0]  char_clks = 16'd100, bit_clks = '0;
    logic             data_ready, trig_req, tmo_req;
    logic [1:0]       irq_id;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    uart_rx_irq_gen #(.CNT_W(CNT_W), .CT_W(CT_W)) i_uart_rx_irq_gen (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_irq_en(rx_irq_en),
        .fifo_count(fifo_count), .trig_level(trig_level), .push(push), .pop(pop),
        .line_err(line_err), .two_stop(two_stop), .char_clks(char_clks),
        .bit_clks(bit_clks), .data_ready(data_ready), .trig_req(trig_req),
        .tmo_req(tmo_req), .irq_id(irq_id)
    );

    // Vector: {line_err, count[4:0], level[4:0], exp_trig, exp_id[1:0]}
    localparam int NV = 12;
    localparam logic [13:0] VEC [NV] = '{
        {1'b0, 5'd2, 5'd4, 1'b0, 2'd0},
        {1'b0, 5'd5, 5'd4, 1'b1, 2'd2},
        {1'b0, 5'd4, 5'd4, 1'b1, 2'd2},
        {1'b0, 5'd3, 5'd4, 1'b0, 2'd0},
        {1'b0, 5'd4, 5'd4, 1'b0, 2'd0},
        {1'b1, 5'd4, 5'd4, 1'b0, 2'd3},
        {1'b1, 5'd9, 5'd4, 1'b1, 2'd3},
        {1'b0, 5'd9, 5'd4, 1'b1, 2'd2},
        {1'b0, 5'd1, 5'd0, 1'b1, 2'd2},
        {1'b0, 5'd0, 5'd0, 1'b1, 2'd2},
        {1'b0, 5'd0, 5'd3, 1'b0, 2'd0},
        {1'b1, 5'd0, 5'd3, 1'b0, 2'd3}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_push();
        @(negedge clk); push = 1'b1;
        @(negedge clk); push = 1'b0;
    endtask

    task automatic pulse_pop();
        @(negedge clk); pop = 1'b1;
        @(negedge clk); pop = 1'b0;
    endtask

    // Count rising edges until tmo_req is seen high.
    task automatic wait_tmo(output int n);
        n = 0;
        while (n < 200) begin
            @(posedge clk); n++;
            #1;
            if (tmo_req) break;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("reset data_ready", data_ready, 0);
        chk("reset irq_id", irq_id, 0);
        chk("reset tmo_req", tmo_req, 0);

        // Table walk: R1 trigger level tracking, R2/R3 priority
        trig_level = 5'd4;
        foreach (VEC[i]) begin
            @(negedge clk);
            line_err   = VEC[i][13];
            fifo_count = VEC[i][12:8];
            trig_level = VEC[i][7:3];
            #1;
            chk($sformatf("R1 trig vec %0d", i), trig_req, VEC[i][2]);
            chk($sformatf("R2 R3 id vec %0d", i), irq_id, VEC[i][1:0]);
        end
        @(negedge clk); line_err = 1'b0; fifo_count = '0; trig_level = 5'd8;

        // R4 data-ready
        pulse_push();
        chk("R4 set after push", data_ready, 1);
        fifo_count = 5'd2;
        @(negedge clk);
        chk("R4 holds", data_ready, 1);
        fifo_count = '0;
        @(negedge clk);
        chk("R4 clear on empty", data_ready, 0);
        rx_irq_en = 1'b0;
        pulse_push();
        chk("R4 independent of enables", data_ready, 1);
        rx_irq_en = 1'b1;

        // R5 timeout with empty FIFO never rises
        char_clks = 16'd5;
        repeat (40) @(negedge clk);
        chk("R5 empty no timeout", tmo_req, 0);

        // R5 timeout timing from push: 4*5+1 = 21 edges
        fifo_count = 5'd1;
        pulse_push();
        wait_tmo(n);
        chk("R5 edges to timeout", n, 21);
        chk("R5 id timeout", irq_id, 1);

        // R2 trigger outranks pending timeout
        @(negedge clk); fifo_count = 5'd9; trig_level = 5'd4;
        #1;
        chk("R2 trig over timeout", irq_id, 2);
        @(negedge clk); fifo_count = 5'd1; trig_level = 5'd8;

        // R7 push while pending keeps timeout
        pulse_push();
        chk("R7 pending survives push", tmo_req, 1);

        // R6 pop clears and restarts
        pulse_pop();
        chk("R6 pop clears", tmo_req, 0);
        wait_tmo(n);
        chk("R6 edges after pop", n, 21);

        // R7 push restarts non-pending timer
        pulse_pop();
        repeat (10) @(negedge clk);
        chk("R7 no early timeout", tmo_req, 0);
        pulse_push();
        wait_tmo(n);
        chk("R7 edges after restart", n, 21);

        // R8 two stop bits preload 3: 20-3+1 = 18
        pulse_pop();
        two_stop = 1'b1; bit_clks = 16'd3;
        pulse_push();
        wait_tmo(n);
        chk("R8 edges with two stop bits", n, 18);
        two_stop = 1'b0;

        // R9 enables gate outputs and timer
        @(negedge clk); fifo_en = 1'b0;
        #1;
        chk("R9 tmo gated", tmo_req, 0);
        @(negedge clk); fifo_en = 1'b1;
        wait_tmo(n);
        chk("R9 full wait after enable", n, 21);
        @(negedge clk);
        rx_irq_en = 1'b0; line_err = 1'b1; fifo_count = 5'd9; trig_level = 5'd4;
        #1;
        chk("R9 id gated", irq_id, 0);
        chk("R9 trig gated", trig_req, 0);
        @(negedge clk); rx_irq_en = 1'b1; line_err = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule